// File: doc/BRIEF.md
# Parallel Flash Chip-Erase Sequencer

This block performs a whole-device erase on a 16-bit parallel NOR-style flash. A single-cycle start request launches a fixed series of six command writes on the flash address and data lines, each latched by a write strobe. The strobe can be formed either on the write-enable line or on the chip-enable line, chosen by a mode input sampled at start. Once the last command word is written, the block polls the device. It issues pairs of output-enable read cycles and compares status bit 6 between the two reads of each pair.

Equal values in a pair mean the erase has finished, and the block pulses `done_o`. If a set number of pairs all disagree, the block gives up, pulses `timeout_o` and parks the bus. Every bus phase lasts a number of clocks set by a parameter, and a zero setting is raised to one clock. The data drivers are enabled only while a command word is on the bus.

Top module: `flash_erase_seq`

## Requirements
- R1: During and directly after reset, busy, done and timeout are low, chip enable, write enable and output enable (all active low) are high, and the data output enable is low.
- R2: A start request produces exactly six write strobes, with (address, data) in the order (5555h,00AAh), (2AAAh,0055h), (5555h,0080h), (5555h,00AAh), (2AAAh,0055h), (5555h,0010h). The upper data byte is driven to 00h, and address bits at position 15 and above are zero.
- R3: With the mode input low at start, write enable is low for PULSE_CYC clocks per word. Chip enable stays low for the whole operation, output enable stays high, and SETUP_CYC+HOLD_CYC clocks separate consecutive strobes.
- R4: With the mode input high at start, chip enable is low for PULSE_CYC clocks per word and high during each word's setup and hold. Write enable is held low across the whole write phase.
- R5: Each poll read holds output enable low for OE_DLY_CYC clocks with chip enable low and write enable high. Output enable then stays high for exactly HOLD_CYC clocks before the next read.
- R6: Reads are taken in non-overlapping pairs, and the operation completes after the first pair whose two reads return the same value on data bit 6. All other data bits are ignored.
- R7: On completion, done is high for exactly one clock, and busy is already low in that clock.
- R8: If POLL_LIMIT pairs in a row disagree on bit 6, timeout is high for one clock and done stays low. Busy is low, and chip enable, write enable and output enable are all high.
- R9: A start request while busy is ignored. It adds no writes, does not change the strobe mode, and does not add a second done pulse.
- R10: The data output enable is high only during write phases and never while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Erase request, sampled while idle |
| ce_ctrl_i | input | 1 | 1: strobe on chip enable, 0: strobe on write enable |
| flash_dq_i | input | 16 | Data read back from the flash |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock pulse on successful completion |
| timeout_o | output | 1 | One-clock pulse when the poll limit is reached |
| flash_addr_o | output | AW | Flash address |
| flash_dq_o | output | 16 | Flash write data |
| flash_dq_oe_o | output | 1 | Drive enable for flash_dq_o |
| flash_ce_n_o | output | 1 | Chip enable, active low |
| flash_we_n_o | output | 1 | Write enable, active low |
| flash_oe_n_o | output | 1 | Output enable, active low |

## Verification
The hardest situation to reach from the ports is a poll that never settles, since a real device finishes its erase on its own. The bench's flash model flips bit 6 at the end of each read for a chosen number of reads. A large count therefore drives the sequencer through every poll pair to the timeout. Small odd and even counts make the first matching pair land at known read numbers. The model also changes every other data bit on each read, so a comparison over the wrong bits would stop polling at the wrong time.

// File: rtl/ferase_pkg.sv
package ferase_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WHOLD  = 3'd3,
        PH_RACT   = 3'd4,
        PH_RHOLD  = 3'd5
    } phase_e;

    localparam int unsigned CMD_WORDS  = 6;
    localparam int unsigned STATUS_BIT = 6;
    localparam int unsigned CMD_AW     = 15;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobes_t;

    // Command address for word index 0..5 of the erase series.
    function automatic logic [CMD_AW-1:0] cmd_addr(input logic [2:0] idx);
        case (idx)
            3'd1, 3'd4: return 15'h2AAA;
            default:    return 15'h5555;
        endcase
    endfunction

    // Low data byte for word index 0..5; the ordering is behaviour.
    function automatic logic [7:0] cmd_byte(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd3: return 8'hAA;
            3'd1, 3'd4: return 8'h55;
            3'd2:       return 8'h80;
            default:    return 8'h10;
        endcase
    endfunction

    function automatic int unsigned min_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels for a phase. ce_mode selects which line carries the strobe:
    // the other one is held low through setup and hold.
    function automatic strobes_t phase_strobes(input phase_e ph, input logic ce_mode);
        strobes_t s;
        s.ce_n  = 1'b1;
        s.we_n  = 1'b1;
        s.oe_n  = 1'b1;
        s.dq_oe = 1'b0;
        case (ph)
            PH_WSETUP, PH_WHOLD: begin
                s.ce_n  = ce_mode;
                s.we_n  = !ce_mode;
                s.dq_oe = 1'b1;
            end
            PH_WPULSE: begin
                s.ce_n  = 1'b0;
                s.we_n  = 1'b0;
                s.dq_oe = 1'b1;
            end
            PH_RACT: begin
                s.ce_n = 1'b0;
                s.oe_n = 1'b0;
            end
            PH_RHOLD: begin
                s.ce_n = 1'b0;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fe_phase_timer.sv
module fe_phase_timer #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart_i,
    input  logic [CW-1:0] len_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= len_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/fe_toggle_pair.sv
module fe_toggle_pair (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic sample_i,
    input  logic bit_i,
    output logic half_o,
    output logic same_o
);
    logic first_q;
    logic half_q;
    logic same_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            first_q <= 1'b0;
            half_q  <= 1'b0;
            same_q  <= 1'b0;
        end else if (sample_i) begin
            if (!half_q) begin
                first_q <= bit_i;
                half_q  <= 1'b1;
            end else begin
                same_q <= (first_q == bit_i);
                half_q <= 1'b0;
            end
        end
    end

    assign half_o = half_q;
    assign same_o = same_q;
endmodule

// File: rtl/fe_bus_map.sv
module fe_bus_map
    import ferase_pkg::*;
#(
    parameter int unsigned AW = 18
) (
    input  phase_e        phase_i,
    input  logic          ce_mode_i,
    input  logic [2:0]    word_i,
    output logic [AW-1:0] addr_o,
    output logic [15:0]   dq_o,
    output logic          dq_oe_o,
    output logic          ce_n_o,
    output logic          we_n_o,
    output logic          oe_n_o
);
    strobes_t st;

    always_comb begin
        st      = phase_strobes(phase_i, ce_mode_i);
        ce_n_o  = st.ce_n;
        we_n_o  = st.we_n;
        oe_n_o  = st.oe_n;
        dq_oe_o = st.dq_oe;
        if (st.dq_oe) begin
            addr_o = AW'(cmd_addr(word_i));
            dq_o   = {8'h00, cmd_byte(word_i)};
        end else begin
            addr_o = '0;
            dq_o   = 16'h0000;
        end
    end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import ferase_pkg::*;
#(
    parameter int unsigned AW         = 18,
    parameter int unsigned SETUP_CYC  = 2,
    parameter int unsigned PULSE_CYC  = 3,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned OE_DLY_CYC = 2,
    parameter int unsigned POLL_LIMIT = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          ce_ctrl_i,
    input  logic [15:0]   flash_dq_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          timeout_o,
    output logic [AW-1:0] flash_addr_o,
    output logic [15:0]   flash_dq_o,
    output logic          flash_dq_oe_o,
    output logic          flash_ce_n_o,
    output logic          flash_we_n_o,
    output logic          flash_oe_n_o
);
    localparam int unsigned SETUP_LEN = min_one(SETUP_CYC);
    localparam int unsigned PULSE_LEN = min_one(PULSE_CYC);
    localparam int unsigned HOLD_LEN  = min_one(HOLD_CYC);
    localparam int unsigned RD_LEN    = min_one(OE_DLY_CYC);
    localparam int unsigned MAX_LEN   = max_of(max_of(SETUP_LEN, PULSE_LEN), max_of(HOLD_LEN, RD_LEN));
    localparam int unsigned CW        = max_of(1, $clog2(MAX_LEN + 1));
    localparam int unsigned LIMIT     = min_one(POLL_LIMIT);
    localparam int unsigned PW        = max_of(1, $clog2(LIMIT + 1));
    localparam logic [2:0]  LAST_WORD = 3'(CMD_WORDS - 1);

    phase_e        phase_q, phase_d;
    logic [2:0]    word_q, word_d;
    logic [PW-1:0] pairs_q, pairs_d;
    logic          mode_q, mode_d;
    logic          done_q, done_d;
    logic          tmo_q, tmo_d;
    logic          restart;
    logic [CW-1:0] len_d;
    logic          last;
    logic          sample;
    logic          tog_clr;
    logic          half;
    logic          same;
    logic          unused_dq;

    assign unused_dq = ^{flash_dq_i[15:STATUS_BIT+1], flash_dq_i[STATUS_BIT-1:0]};

    fe_phase_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .len_i     (len_d),
        .last_o    (last)
    );

    assign sample = (phase_q == PH_RACT) && last;

    fe_toggle_pair u_toggle (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (tog_clr),
        .sample_i (sample),
        .bit_i    (flash_dq_i[STATUS_BIT]),
        .half_o   (half),
        .same_o   (same)
    );

    fe_bus_map #(.AW(AW)) u_bus (
        .phase_i   (phase_q),
        .ce_mode_i (mode_q),
        .word_i    (word_q),
        .addr_o    (flash_addr_o),
        .dq_o      (flash_dq_o),
        .dq_oe_o   (flash_dq_oe_o),
        .ce_n_o    (flash_ce_n_o),
        .we_n_o    (flash_we_n_o),
        .oe_n_o    (flash_oe_n_o)
    );

    // Next phase, and the bookkeeping that moves with it.
    always_comb begin
        phase_d = phase_q;
        word_d  = word_q;
        pairs_d = pairs_q;
        mode_d  = mode_q;
        done_d  = 1'b0;
        tmo_d   = 1'b0;
        tog_clr = 1'b0;
        restart = 1'b0;
        if (phase_q == PH_IDLE) begin
            if (start_i) begin
                phase_d = PH_WSETUP;
                word_d  = '0;
                pairs_d = '0;
                mode_d  = ce_ctrl_i;
                tog_clr = 1'b1;
                restart = 1'b1;
            end
        end else if (last) begin
            restart = 1'b1;
            case (phase_q)
                PH_WSETUP: phase_d = PH_WPULSE;
                PH_WPULSE: phase_d = PH_WHOLD;
                PH_WHOLD: begin
                    if (word_q == LAST_WORD) begin
                        phase_d = PH_RACT;
                    end else begin
                        word_d  = word_q + 3'd1;
                        phase_d = PH_WSETUP;
                    end
                end
                PH_RACT: phase_d = PH_RHOLD;
                PH_RHOLD: begin
                    if (half) begin
                        phase_d = PH_RACT;
                    end else if (same) begin
                        phase_d = PH_IDLE;
                        done_d  = 1'b1;
                        restart = 1'b0;
                    end else if (pairs_q == PW'(LIMIT - 1)) begin
                        phase_d = PH_IDLE;
                        tmo_d   = 1'b1;
                        restart = 1'b0;
                    end else begin
                        pairs_d = pairs_q + 1'b1;
                        phase_d = PH_RACT;
                    end
                end
                default: begin
                    phase_d = PH_IDLE;
                    restart = 1'b0;
                end
            endcase
        end
    end

    // Length of the phase being entered.
    always_comb begin
        case (phase_d)
            PH_WSETUP: len_d = CW'(SETUP_LEN);
            PH_WPULSE: len_d = CW'(PULSE_LEN);
            PH_WHOLD:  len_d = CW'(HOLD_LEN);
            PH_RACT:   len_d = CW'(RD_LEN);
            PH_RHOLD:  len_d = CW'(HOLD_LEN);
            default:   len_d = CW'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            word_q  <= '0;
            pairs_q <= '0;
            mode_q  <= 1'b0;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            word_q  <= word_d;
            pairs_q <= pairs_d;
            mode_q  <= mode_d;
            done_q  <= done_d;
            tmo_q   <= tmo_d;
        end
    end

    assign busy_o    = (phase_q != PH_IDLE);
    assign done_o    = done_q;
    assign timeout_o = tmo_q;
endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
    parameter int unsigned AW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          tmo,
    input logic          ce_n,
    input logic          we_n,
    input logic          oe_n,
    input logic          dq_oe,
    input logic [AW-1:0] addr
);
    assert_no_contention_R10: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> oe_n);

    assert_read_strobes_R5: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (!ce_n && we_n));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_tmo_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        tmo |=> !tmo);

    assert_idle_bus_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ce_n && we_n && oe_n && !dq_oe));

    assert_outcome_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(done && tmo));

    assert_cmd_addr_R2: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> ((addr >> 15) == '0));
endmodule

bind flash_erase_seq fe_checker #(.AW(AW)) u_fe_checker (
    .clk   (clk),
    .rst   (rst),
    .busy  (busy_o),
    .done  (done_o),
    .tmo   (timeout_o),
    .ce_n  (flash_ce_n_o),
    .we_n  (flash_we_n_o),
    .oe_n  (flash_oe_n_o),
    .dq_oe (flash_dq_oe_o),
    .addr  (flash_addr_o)
);

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/1ps
module test_flash_erase_seq;
    localparam int AW = 18;
    localparam int SU = 2;
    localparam int PU = 3;
    localparam int HD = 1;
    localparam int OD = 2;
    localparam int PL = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          ce_ctrl = 1'b0;
    logic [15:0]   dq_in;
    logic          busy, done, tmo;
    logic [AW-1:0] addr;
    logic [15:0]   dq_out;
    logic          dq_oe, ce_n, we_n, oe_n;

    always #4 clk = ~clk;

    flash_erase_seq #(
        .AW(AW), .SETUP_CYC(SU), .PULSE_CYC(PU), .HOLD_CYC(HD),
        .OE_DLY_CYC(OD), .POLL_LIMIT(PL)
    ) i_flash_erase_seq (
        .clk(clk), .rst(rst), .start_i(start), .ce_ctrl_i(ce_ctrl),
        .flash_dq_i(dq_in), .busy_o(busy), .done_o(done), .timeout_o(tmo),
        .flash_addr_o(addr), .flash_dq_o(dq_out), .flash_dq_oe_o(dq_oe),
        .flash_ce_n_o(ce_n), .flash_we_n_o(we_n), .flash_oe_n_o(oe_n)
    );

    int tests = 0;
    int fails = 0;

    // Flash model and bus monitor state
    logic        dev_dq6 = 1'b0;
    logic [15:0] noise = 16'h3C5A;
    int dev_left = 0;
    int n_wr, n_rd, s_w, r_w, gap, rgap;
    int gap_bad, rw_bad, rgap_bad, ww_bad, cont, xbad;
    int ce_hi, we_lo, done_cnt, tmo_cnt;
    logic busy_at_done, busy_at_tmo;
    logic prev_s = 1'b0, prev_r = 1'b0;
    logic [AW-1:0] s_addr;
    logic [15:0]   s_data;
    logic [AW-1:0] wr_addr [8];
    logic [15:0]   wr_data [8];

    assign dq_in = {noise[15:7], dev_dq6, noise[5:0]};

    always @(negedge clk) begin
        if (!rst) begin
            if (!ce_n && !we_n && oe_n) begin
                if (!prev_s && n_wr > 0 && gap != SU + HD) gap_bad++;
                s_w++;
                s_addr = addr;
                s_data = dq_oe ? dq_out : 16'hDEAD;
                prev_s = 1'b1;
            end else begin
                if (prev_s) begin
                    if (n_wr < 8) begin
                        wr_addr[n_wr] = s_addr;
                        wr_data[n_wr] = s_data;
                    end
                    if (s_w != PU) ww_bad++;
                    n_wr++;
                    s_w = 0;
                    gap = 1;
                end else begin
                    gap++;
                end
                prev_s = 1'b0;
            end
            if (!ce_n && !oe_n) begin
                if (!prev_r && n_rd > 0 && rgap != HD) rgap_bad++;
                r_w++;
                prev_r = 1'b1;
            end else begin
                if (prev_r) begin
                    if (r_w != OD) rw_bad++;
                    n_rd++;
                    r_w = 0;
                    rgap = 1;
                    if (dev_left > 0) begin
                        dev_dq6 = ~dev_dq6;
                        dev_left--;
                    end
                    noise = {noise[14:0], noise[15] ^ noise[13]} ^ 16'h9B41;
                end else begin
                    rgap++;
                end
                prev_r = 1'b0;
            end
            if (dq_oe && !oe_n) cont++;
            if (dq_oe && $isunknown(dq_out)) xbad++;
            if (busy && ce_n) ce_hi++;
            if (busy && !we_n) we_lo++;
            if (done) begin done_cnt++; busy_at_done = busy; end
            if (tmo) begin tmo_cnt++; busy_at_tmo = busy; end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_wr = 0; n_rd = 0; s_w = 0; r_w = 0; gap = 0; rgap = 0;
        gap_bad = 0; rw_bad = 0; rgap_bad = 0; ww_bad = 0; cont = 0; xbad = 0;
        ce_hi = 0; we_lo = 0; done_cnt = 0; tmo_cnt = 0;
        busy_at_done = 1'b0; busy_at_tmo = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done_cnt > 0 || tmo_cnt > 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic run_op(input logic mode, input int toggles);
        clear_mon();
        ce_ctrl = mode;
        dev_left = toggles;
        pulse_start();
        wait_end();
    endtask

    task automatic check_cmds(input string req);
        logic [14:0] ea [6] = '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h2AAA, 15'h5555};
        logic [7:0]  ed [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
        chk(n_wr == 6, req, "write count", n_wr, 6);
        for (int i = 0; i < 6; i++) begin
            chk(wr_addr[i] == AW'(ea[i]), req, $sformatf("addr word %0d", i), wr_addr[i], ea[i]);
            chk(wr_data[i] == {8'h00, ed[i]}, req, $sformatf("data word %0d", i), wr_data[i], ed[i]);
        end
        chk(xbad == 0, req, "undriven data bits", xbad, 0);
    endtask

    task automatic test_reset();
        logic [6:0] v;
        v = {busy, done, tmo, ce_n, we_n, oe_n, dq_oe};
        chk(v == 7'b0001110, "R1", "outputs in reset", v, 7'b0001110);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        v = {busy, done, tmo, ce_n, we_n, oe_n, dq_oe};
        chk(v == 7'b0001110, "R1", "outputs after reset", v, 7'b0001110);
    endtask

    task automatic test_we_mode();
        run_op(1'b0, 5);
        check_cmds("R2");
        chk(ww_bad == 0, "R3", "write pulse width errors", ww_bad, 0);
        chk(gap_bad == 0, "R3", "strobe spacing errors", gap_bad, 0);
        chk(ce_hi == 0, "R3", "busy clocks with CE high", ce_hi, 0);
        chk(we_lo == 6 * PU, "R3", "busy clocks with WE low", we_lo, 6 * PU);
        chk(rw_bad == 0, "R5", "read width errors", rw_bad, 0);
        chk(rgap_bad == 0, "R5", "read spacing errors", rgap_bad, 0);
        chk(n_rd == 8, "R6", "reads for 5 toggles", n_rd, 8);
        chk(done_cnt == 1, "R7", "done clocks", done_cnt, 1);
        chk(busy_at_done == 1'b0, "R7", "busy during done", busy_at_done, 0);
        chk(tmo_cnt == 0, "R8", "timeout without cause", tmo_cnt, 0);
        chk(cont == 0, "R10", "drive while OE low", cont, 0);
    endtask

    task automatic test_ce_mode();
        run_op(1'b1, 1);
        check_cmds("R4");
        chk(ww_bad == 0, "R4", "CE pulse width errors", ww_bad, 0);
        chk(gap_bad == 0, "R4", "strobe spacing errors", gap_bad, 0);
        chk(ce_hi == 6 * (SU + HD), "R4", "busy clocks with CE high", ce_hi, 6 * (SU + HD));
        chk(we_lo == 6 * (SU + PU + HD), "R4", "busy clocks with WE low", we_lo, 6 * (SU + PU + HD));
        chk(n_rd == 4, "R6", "reads for 1 toggle", n_rd, 4);
        chk(done_cnt == 1, "R7", "done clocks", done_cnt, 1);
        chk(cont == 0, "R10", "drive while OE low", cont, 0);
    endtask

    task automatic test_settled();
        run_op(1'b0, 0);
        chk(n_rd == 2, "R6", "reads when already settled", n_rd, 2);
        chk(done_cnt == 1, "R6", "done when already settled", done_cnt, 1);
        run_op(1'b0, 4);
        chk(n_rd == 6, "R6", "reads for 4 toggles", n_rd, 6);
        chk(rgap_bad == 0, "R5", "read spacing errors", rgap_bad, 0);
    endtask

    task automatic test_timeout();
        logic [3:0] pins;
        run_op(1'b0, 1000);
        chk(tmo_cnt == 1, "R8", "timeout clocks", tmo_cnt, 1);
        chk(done_cnt == 0, "R8", "done on timeout", done_cnt, 0);
        chk(n_rd == 2 * PL, "R8", "reads before timeout", n_rd, 2 * PL);
        chk(busy_at_tmo == 1'b0, "R8", "busy during timeout", busy_at_tmo, 0);
        pins = {busy, ce_n, we_n, oe_n};
        chk(pins == 4'b0111, "R8", "bus after timeout", pins, 4'b0111);
        dev_left = 0;
    endtask

    task automatic test_busy_start();
        clear_mon();
        ce_ctrl = 1'b0;
        dev_left = 3;
        pulse_start();
        repeat (5) @(negedge clk);
        ce_ctrl = 1'b1;
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        wait_end();
        chk(n_wr == 6, "R9", "writes with extra starts", n_wr, 6);
        chk(ce_hi == 0, "R9", "mode kept while busy", ce_hi, 0);
        chk(done_cnt == 1, "R9", "done clocks with extra starts", done_cnt, 1);
        chk(n_rd == 6, "R9", "reads with extra starts", n_rd, 6);
        ce_ctrl = 1'b0;
    endtask

    initial begin
        clear_mon();
        repeat (5) @(negedge clk);
        test_reset();
        test_we_mode();
        test_ce_mode();
        test_settled();
        test_timeout();
        test_busy_start();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule